// File: doc/BRIEF.md
# ISA I/O Window Address Decoder

This block sits behind a 16-bit ISA I/O port and decides whether a bus cycle belongs to a card with four function units. A six-position base-address switch is compared against address bits 9..4. The top nibble of the address must hold the fixed window prefix Ah. Address bits 11..10 then pick one of four 16-byte unit windows, which lie at A000h, A400h, A800h and AC00h above the base. The four low address bits pass through as the register offset inside the selected window.

Read and write strobes count only while AEN is low. They are qualified into per-unit read and write enables. Two offsets in every window are answered by the decoder itself. Eh returns an ASCII lowercase letter naming the unit's circuit type, and Fh returns the unit's circuit number. Every other offset returns the data the selected unit presents. The decoder drives the data bus only during a qualified read of its own window. Any matching cycle also lights an activity lamp, which a counter holds on long enough to be seen.

Top module: `isa_io_window_decoder`

## Requirements
- R1: A cycle is a hit only when sa[9:4] equals base_sw, sa[15:12] equals 4'hA, aen is low, and at least one of ior_n or iow_n is low.
- R2: On a hit, exactly the unit_sel bit indexed by sa[11:10] is high (bit 0 = A000h window, bit 3 = AC00h window). Otherwise unit_sel is all zero.
- R3: reg_off always equals sa[3:0]. unit_rd is high exactly when there is a hit with ior_n low. unit_wr is high exactly when there is a hit with iow_n low.
- R4: While aen is high, no unit is selected and the data bus is not driven, whatever the address and strobes.
- R5: A qualified read at offset 4'hE returns byte u of id_letter for the selected unit u (bits 8u+7..8u).
- R6: A qualified read at offset 4'hF returns byte u of id_num for the selected unit u. The full range 0 to 255 passes unchanged.
- R7: A qualified read at any other offset returns byte u of unit_rdata for the selected unit u.
- R8: sd_oe is high only during a qualified read. When sd_oe is low, sd_out is zero.
- R9: act_led goes high after the first clock edge that samples a hit. It stays high for exactly STRETCH_CYC edges after the last edge that samples a hit, and a new hit restarts the count.
- R10: After reset, act_led is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the activity stretcher |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_sw | input | 6 | Base-address switch setting, compared with sa[9:4] |
| sa | input | 16 | ISA I/O address |
| aen | input | 1 | DMA address enable; high blocks decoding |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| id_letter | input | 32 | Per-unit circuit type letter, byte u for unit u |
| id_num | input | 32 | Per-unit circuit number, byte u for unit u |
| unit_rdata | input | 32 | Per-unit register read data, byte u for unit u |
| unit_sel | output | 4 | One-hot unit window select |
| reg_off | output | 4 | Register offset inside the window |
| unit_rd | output | 1 | Qualified read enable |
| unit_wr | output | 1 | Qualified write enable |
| sd_out | output | 8 | Read data toward the bus |
| sd_oe | output | 1 | Data bus output enable |
| act_led | output | 1 | Stretched activity indicator |

## Verification
The decode path has no storage, so a wrong compare or index shows up at the ports in the same cycle. It appears as a second select bit, a select for a foreign address, or a driven bus during a write or while AEN is high. The only state is the stretch counter. A wrong load value or a missing restart changes the cycle on which act_led falls, so the lamp is checked edge by edge over its whole window.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;
   localparam int ADDR_W    = 16;
   localparam int OFF_W     = 4;
   localparam int BASE_W    = 6;
   localparam int UNIT_W    = 2;
   localparam int PFX_W     = 4;
   localparam int DATA_W    = 8;
   localparam int NUM_UNITS = 1 << UNIT_W;

   localparam logic [OFF_W-1:0] OFF_ID_TYPE = 4'hE;
   localparam logic [OFF_W-1:0] OFF_ID_NUM  = 4'hF;

   // Field layout of an I/O address, MSB first
   typedef struct packed {
      logic [PFX_W-1:0]  pfx;
      logic [UNIT_W-1:0] unit;
      logic [BASE_W-1:0] base;
      logic [OFF_W-1:0]  off;
   } io_addr_t;
endpackage

// File: rtl/iwd_match.sv
module iwd_match
   import isa_win_pkg::*;
#(
   parameter logic [PFX_W-1:0] PREFIX = 4'hA
) (
   input  io_addr_t          addr,
   input  logic [BASE_W-1:0] base_sw,
   input  logic              aen,
   input  logic              ior_n,
   input  logic              iow_n,
   output logic              hit,
   output logic              rd,
   output logic              wr
);
   logic addr_ok;
   logic strobe;

   always_comb begin
      addr_ok = (addr.base == base_sw) && (addr.pfx == PREFIX);
      strobe  = !ior_n || !iow_n;
      hit     = addr_ok && !aen && strobe;
      rd      = hit && !ior_n;
      wr      = hit && !iow_n;
   end
endmodule

// File: rtl/iwd_unit_demux.sv
module iwd_unit_demux
   import isa_win_pkg::*;
(
   input  logic                 hit,
   input  logic [UNIT_W-1:0]    unit,
   output logic [NUM_UNITS-1:0] sel
);
   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_sel
      assign sel[u] = hit && (unit == UNIT_W'(u));
   end
endmodule

// File: rtl/iwd_read_mux.sv
module iwd_read_mux
   import isa_win_pkg::*;
#(
   parameter bit HAS_ID = 1'b1
) (
   input  logic                        rd,
   input  logic [UNIT_W-1:0]           unit,
   input  logic [OFF_W-1:0]            off,
   input  logic [NUM_UNITS*DATA_W-1:0] id_letter,
   input  logic [NUM_UNITS*DATA_W-1:0] id_num,
   input  logic [NUM_UNITS*DATA_W-1:0] unit_rdata,
   output logic [DATA_W-1:0]           dout,
   output logic                        oe
);
   logic [DATA_W-1:0] reg_byte;
   logic [DATA_W-1:0] sel_byte;

   assign reg_byte = unit_rdata[unit*DATA_W +: DATA_W];

   if (HAS_ID) begin : g_id
      always_comb begin
         unique case (off)
            OFF_ID_TYPE: sel_byte = id_letter[unit*DATA_W +: DATA_W];
            OFF_ID_NUM:  sel_byte = id_num[unit*DATA_W +: DATA_W];
            default:     sel_byte = reg_byte;
         endcase
      end
   end else begin : g_noid
      logic unused_id;
      assign unused_id = ^{id_letter, id_num, off};
      assign sel_byte  = reg_byte;
   end

   assign oe   = rd;
   assign dout = rd ? sel_byte : '0;
endmodule

// File: rtl/iwd_act_stretch.sv
module iwd_act_stretch #(
   parameter int STRETCH_CYC = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic led
);
   localparam int CNT_W = $clog2(STRETCH_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYC);

   if (STRETCH_CYC < 1) begin : g_bad
      $error("STRETCH_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (trig)       cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign led = (cnt != '0);

   AST_LED_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> led) else $error("lamp not lit after hit"); // R9
endmodule

// File: rtl/isa_io_window_decoder.sv
module isa_io_window_decoder
   import isa_win_pkg::*;
#(
   parameter logic [PFX_W-1:0] PREFIX      = 4'hA,
   parameter int               STRETCH_CYC = 2_500_000,
   parameter bit               HAS_ID      = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [BASE_W-1:0]           base_sw,
   input  logic [ADDR_W-1:0]           sa,
   input  logic                        aen,
   input  logic                        ior_n,
   input  logic                        iow_n,
   input  logic [NUM_UNITS*DATA_W-1:0] id_letter,
   input  logic [NUM_UNITS*DATA_W-1:0] id_num,
   input  logic [NUM_UNITS*DATA_W-1:0] unit_rdata,
   output logic [NUM_UNITS-1:0]        unit_sel,
   output logic [OFF_W-1:0]            reg_off,
   output logic                        unit_rd,
   output logic                        unit_wr,
   output logic [DATA_W-1:0]           sd_out,
   output logic                        sd_oe,
   output logic                        act_led
);
   if (PFX_W + UNIT_W + BASE_W + OFF_W != ADDR_W) begin : g_bad_layout
      $error("address fields do not cover the address width");
   end

   io_addr_t addr;
   logic     hit;

   assign addr    = io_addr_t'(sa);
   assign reg_off = addr.off;

   iwd_match #(.PREFIX(PREFIX)) u_match (
      .addr(addr), .base_sw(base_sw), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
      .hit(hit), .rd(unit_rd), .wr(unit_wr)
   );

   iwd_unit_demux u_demux (
      .hit(hit), .unit(addr.unit), .sel(unit_sel)
   );

   iwd_read_mux #(.HAS_ID(HAS_ID)) u_rmux (
      .rd(unit_rd), .unit(addr.unit), .off(addr.off),
      .id_letter(id_letter), .id_num(id_num), .unit_rdata(unit_rdata),
      .dout(sd_out), .oe(sd_oe)
   );

   iwd_act_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_act (
      .clk(clk), .rst_n(rst_n), .trig(hit), .led(act_led)
   );

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unit_sel)) else $error("more than one window selected"); // R2
   AST_SEL_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_sel != '0) |-> (sa[9:4] == base_sw && sa[15:12] == PREFIX))
      else $error("select without address match"); // R1
   AST_AEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      aen |-> (unit_sel == '0 && !sd_oe)) else $error("activity while aen high"); // R4
   AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      sd_oe |-> (!ior_n && unit_sel != '0)) else $error("bus driven outside a read"); // R8
endmodule

// File: tb/tb_isa_io_window_decoder.sv
module tb_isa_io_window_decoder;
   localparam int STR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  base_sw = 6'h15;
   logic [15:0] sa = '0;
   logic        aen = 1'b0, ior_n = 1'b1, iow_n = 1'b1;
   logic [31:0] id_letter = {"f", "t", "g", "n"};
   logic [31:0] id_num    = {8'd32, 8'd255, 8'd1, 8'd0};
   logic [31:0] unit_rdata = 32'hD4C3B2A1;
   logic [3:0]  unit_sel, reg_off;
   logic        unit_rd, unit_wr, sd_oe, act_led;
   logic [7:0]  sd_out;

   int total = 0, bad = 0;

   typedef struct packed {
      logic [3:0] sel; logic [3:0] off; logic rd; logic wr; logic oe; logic [7:0] d;
   } obs_t;
   typedef struct { obs_t e; string req; } exp_t;
   exp_t q[$];
   event sample_ev;

   always #10 clk = ~clk;

   isa_io_window_decoder #(.STRETCH_CYC(STR)) dut (.*);

   function automatic obs_t model(logic [15:0] a, logic [5:0] b, logic en, logic r_n, logic w_n);
      obs_t o;
      logic h;
      int u;
      h = (a[9:4] == b) && (a[15:12] == 4'hA) && !en && (!r_n || !w_n);
      u = int'(a[11:10]);
      o.sel = h ? (4'b1 << u) : 4'b0;
      o.off = a[3:0];
      o.rd = h && !r_n;
      o.wr = h && !w_n;
      o.oe = o.rd;
      if (!o.rd)              o.d = 8'h00;
      else if (a[3:0] == 4'hE) o.d = id_letter[u*8 +: 8];
      else if (a[3:0] == 4'hF) o.d = id_num[u*8 +: 8];
      else                     o.d = unit_rdata[u*8 +: 8];
      return o;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(string req, logic [15:0] a, logic en, logic r_n, logic w_n);
      exp_t x;
      @(negedge clk);
      sa = a; aen = en; ior_n = r_n; iow_n = w_n;
      x.e = model(a, base_sw, en, r_n, w_n);
      x.req = req;
      q.push_back(x);
      #5 -> sample_ev;
   endtask

   initial begin : monitor
      forever begin
         @(sample_ev);
         if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            check(x.req, 32'({unit_sel, reg_off, unit_rd, unit_wr, sd_oe, sd_out}), 32'(x.e));
         end
      end
   end

   function automatic logic [15:0] adr(int u, logic [5:0] b, logic [3:0] off);
      return 16'hA000 | 16'(u << 10) | 16'(b << 4) | 16'(off);
   endfunction

   task automatic idle();
      @(negedge clk);
      sa = '0; aen = 1'b0; ior_n = 1'b1; iow_n = 1'b1;
   endtask

   initial begin : watchdog
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      #1;
      check("R10 led in reset", 32'(act_led), 32'd0);
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      @(negedge clk);
      check("R10 led after reset", 32'(act_led), 32'd0);
      check("R2 no sel idle", 32'(unit_sel), 32'd0);

      for (int u = 0; u < 4; u++) begin
         drive("R5 type letter", adr(u, base_sw, 4'hE), 1'b0, 1'b0, 1'b1);
         drive("R6 circuit number", adr(u, base_sw, 4'hF), 1'b0, 1'b0, 1'b1);
         drive("R7 unit reg read", adr(u, base_sw, 4'h3), 1'b0, 1'b0, 1'b1);
         drive("R3 write qualified", adr(u, base_sw, 4'h0), 1'b0, 1'b1, 1'b0);
      end
      drive("R4 aen blocks read", adr(2, base_sw, 4'hE), 1'b1, 1'b0, 1'b1);
      drive("R4 aen blocks write", adr(1, base_sw, 4'h5), 1'b1, 1'b1, 1'b0);
      drive("R1 wrong base", adr(0, 6'h14, 4'hE), 1'b0, 1'b0, 1'b1);
      drive("R1 wrong prefix", 16'hB150 | 16'h000E, 1'b0, 1'b0, 1'b1);
      drive("R1 no strobe", adr(3, base_sw, 4'hF), 1'b0, 1'b1, 1'b1);
      drive("R8 both strobes", adr(1, base_sw, 4'hF), 1'b0, 1'b0, 1'b0);
      drive("R3 offset passes", 16'h1237, 1'b0, 1'b1, 1'b1);
      @(negedge clk); base_sw = 6'h3F;
      drive("R1 top base", adr(3, 6'h3F, 4'hE), 1'b0, 1'b0, 1'b1);
      drive("R2 top unit edge", 16'hAFFF, 1'b0, 1'b0, 1'b1);
      @(negedge clk); base_sw = 6'h00;
      drive("R1 zero base", 16'hA00D, 1'b0, 1'b0, 1'b1);
      idle();
      repeat (STR + 2) @(negedge clk);
      check("R9 led idle off", 32'(act_led), 32'd0);

      // lamp window: one hit, then exactly STR edges lit
      @(negedge clk); sa = 16'hA402; iow_n = 1'b0;
      @(negedge clk); sa = '0; iow_n = 1'b1;
      check("R9 led lit after hit", 32'(act_led), 32'd1);
      repeat (STR - 1) @(negedge clk);
      check("R9 led last lit edge", 32'(act_led), 32'd1);
      @(negedge clk);
      check("R9 led off after window", 32'(act_led), 32'd0);

      // retrigger halfway
      @(negedge clk); sa = 16'hA800; ior_n = 1'b0;
      @(negedge clk); sa = '0; ior_n = 1'b1;
      repeat (STR / 2) @(negedge clk);
      sa = 16'hAC0E; ior_n = 1'b0;
      @(negedge clk); sa = '0; ior_n = 1'b1;
      repeat (STR - 1) @(negedge clk);
      check("R9 retrigger extends", 32'(act_led), 32'd1);
      @(negedge clk);
      check("R9 retrigger ends", 32'(act_led), 32'd0);

      // aen-blocked cycle must not light the lamp
      @(negedge clk); sa = 16'hA000; aen = 1'b1; ior_n = 1'b0;
      @(negedge clk); aen = 1'b0; ior_n = 1'b1; sa = '0;
      check("R4 aen no lamp", 32'(act_led), 32'd0);

      repeat (2) @(negedge clk);
      check("R2 queue drained", 32'(q.size()), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule